// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by consulting two direction predictors and letting a third table decide, branch by branch, which one to trust. The first component is a plain table of 2-bit saturating counters indexed by the branch address alone. The second is a correlating table. The branch address picks a set of four 2-bit counters, and a 2-bit register of recent global outcomes picks one counter within that set. A chooser table of 2-bit counters, also indexed by branch address, learns which of the two components has been right more often for each branch.

A fetch stage presents a lookup address and reads the prediction in the same cycle, together with a flag saying whether the correlating component supplied it. When a branch resolves, the execute stage sends its address and actual outcome on the update port. On that clock edge both components train, the chooser moves toward whichever component alone was right, and the outcome is shifted into the global history.

Every counter is treated as a four-state machine. Component counter states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome moves a counter one state toward STRONG_T and a not-taken outcome moves it one state toward STRONG_NT, and each end state holds. Chooser states are FAVOUR_BIM_STRONG (00), FAVOUR_BIM_WEAK (01), FAVOUR_COR_WEAK (10) and FAVOUR_COR_STRONG (11). The transition "correlator only right" moves a chooser counter one step up. The transition "simple table only right" moves it one step down. The transition "tie" leaves it where it is.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every component counter is WEAK_NT (01), every chooser counter is FAVOUR_BIM_WEAK (01) and the history is 00, so every lookup gives pred_taken=0 and pred_from_cor=0.
- R2: A component counter steps up by one on a taken outcome and down by one on a not-taken outcome, saturating at 11 and 00. It predicts taken in states 10 and 11, so from a strong state the prediction flips only after two misses in a row.
- R3: The simple component is indexed by address bits [BIM_W+1:2], where BIM_W = log2(BIM_ENTRIES). Addresses that agree in those bits share a counter.
- R4: The correlating component is indexed by {address bits [SET_W+1:2], history}, where SET_W = log2(COR_SETS). The history value selects one of the four counters in the set.
- R5: The chooser is indexed by address bits [SEL_W+1:2]. In states 10 and 11 it selects the correlating component, and then pred_from_cor=1 and pred_taken is that component's prediction. In states 00 and 01 it selects the simple component, and then pred_from_cor=0.
- R6: On an update, the chooser entry steps up (saturating at 11) when only the correlating component predicted the outcome correctly. It steps down (saturating at 00) when only the simple component did. It is unchanged when both were right or both were wrong.
- R7: Both components train on every update, whichever component was selected.
- R8: On every update the history becomes {old bit 0, outcome}. Bit 0 always holds the most recent outcome.
- R9: A lookup is combinational from lk_pc. An update changes lookups from the next cycle on, and the tables and history do not change in a cycle with upd_valid=0, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| pred_taken | output | 1 | Predicted direction for lk_pc |
| pred_from_cor | output | 1 | 1 when the correlating component supplied the prediction |

## Verification
The bench trains a branch with an alternating outcome pattern. The simple counter keeps missing on that branch while the history-selected counters learn it, so the chooser has to cross from the simple side to the correlating side. A design that swapped the meaning of the chooser states, or let the chooser move on a tie, would show the wrong pred_from_cor or the wrong direction. Addresses that alias in one table but not in another are mixed into the stream. An index built from the wrong address bits, or history shifted in the wrong direction, would then mispredict against the reference model. Saturation at both ends is driven by long runs of one outcome. Cycles with upd_valid low carry junk on the update inputs, and a design that trained on them would change later lookups.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        STRONG_NT = 2'b00,
        WEAK_NT   = 2'b01,
        WEAK_T    = 2'b10,
        STRONG_T  = 2'b11
    } ctr_t;

    typedef enum logic [1:0] {
        FAVOUR_BIM_STRONG = 2'b00,
        FAVOUR_BIM_WEAK   = 2'b01,
        FAVOUR_COR_WEAK   = 2'b10,
        FAVOUR_COR_STRONG = 2'b11
    } sel_t;

    function automatic ctr_t ctr_next(ctr_t s, logic taken);
        ctr_t r;
        r = s;
        unique case (s)
            STRONG_NT: r = taken ? WEAK_NT  : STRONG_NT;
            WEAK_NT:   r = taken ? WEAK_T   : STRONG_NT;
            WEAK_T:    r = taken ? STRONG_T : WEAK_NT;
            STRONG_T:  r = taken ? STRONG_T : WEAK_T;
        endcase
        return r;
    endfunction

    function automatic logic ctr_says_taken(ctr_t s);
        return (s == WEAK_T) || (s == STRONG_T);
    endfunction

    function automatic sel_t sel_next(sel_t s, logic cor_ok, logic bim_ok);
        sel_t r;
        r = s;
        if (cor_ok && !bim_ok) begin
            unique case (s)
                FAVOUR_BIM_STRONG: r = FAVOUR_BIM_WEAK;
                FAVOUR_BIM_WEAK:   r = FAVOUR_COR_WEAK;
                FAVOUR_COR_WEAK:   r = FAVOUR_COR_STRONG;
                FAVOUR_COR_STRONG: r = FAVOUR_COR_STRONG;
            endcase
        end else if (bim_ok && !cor_ok) begin
            unique case (s)
                FAVOUR_BIM_STRONG: r = FAVOUR_BIM_STRONG;
                FAVOUR_BIM_WEAK:   r = FAVOUR_BIM_STRONG;
                FAVOUR_COR_WEAK:   r = FAVOUR_BIM_WEAK;
                FAVOUR_COR_STRONG: r = FAVOUR_COR_WEAK;
            endcase
        end
        return r;
    endfunction

    function automatic logic sel_picks_cor(sel_t s);
        return (s == FAVOUR_COR_WEAK) || (s == FAVOUR_COR_STRONG);
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_state,
    input  logic [IDX_W-1:0] up_idx,
    output ctr_t             up_state,
    input  logic             wr_en,
    input  logic             wr_taken
);

    ctr_t mem_q [ENTRIES];

    // State register process: one 2-bit state machine per entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= WEAK_NT;
            end
        end else if (wr_en) begin
            mem_q[up_idx] <= ctr_next(mem_q[up_idx], wr_taken);
        end
    end

    // Output process
    always_comb begin
        rd_state = mem_q[rd_idx];
        up_state = mem_q[up_idx];
    end

    // R2: a taken outcome never lowers the trained counter
    assert_ctr_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> (mem_q[$past(up_idx)] >= $past(mem_q[up_idx])));

    // R2: a not-taken outcome never raises the trained counter
    assert_ctr_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> (mem_q[$past(up_idx)] <= $past(mem_q[up_idx])));

    // R9: without a write the addressed entry holds
    assert_ctr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem_q[$past(rd_idx)] == $past(mem_q[rd_idx])));

endmodule

// File: rtl/bp_selector.sv
module bp_selector
    import bp_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_use_cor,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             wr_en,
    input  logic             cor_ok,
    input  logic             bim_ok
);

    sel_t mem_q [ENTRIES];

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= FAVOUR_BIM_WEAK;
            end
        end else if (wr_en) begin
            mem_q[up_idx] <= sel_next(mem_q[up_idx], cor_ok, bim_ok);
        end
    end

    // Output process
    always_comb begin
        rd_use_cor = sel_picks_cor(mem_q[rd_idx]);
    end

    // R6: a tie in correctness leaves the chooser entry alone
    assert_sel_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cor_ok == bim_ok)) |=> (mem_q[$past(up_idx)] == $past(mem_q[up_idx])));

    // R6: only the correlator right never moves toward the simple side
    assert_sel_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cor_ok && !bim_ok) |=> (mem_q[$past(up_idx)] >= $past(mem_q[up_idx])));

    // R6: only the simple table right never moves toward the correlator
    assert_sel_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bim_ok && !cor_ok) |=> (mem_q[$past(up_idx)] <= $past(mem_q[up_idx])));

endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            if (HIST_W > 1) begin
                hist_q <= {hist_q[HIST_W-2:0], taken};
            end else begin
                hist_q <= taken;
            end
        end
    end

    always_comb begin
        hist = hist_q;
    end

    // R8: newest outcome lands in bit 0
    assert_hist_newest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(taken)));

    generate
        if (HIST_W > 1) begin : g_older
            // R8: older bits move up by one place
            assert_hist_older_R8: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
        end
    endgenerate

    // R9: no update, no history change
    assert_hist_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int BIM_ENTRIES = 256,
    parameter int COR_SETS    = 64,
    parameter int SEL_ENTRIES = 256,
    parameter int HIST_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            pred_taken,
    output logic            pred_from_cor
);

    localparam int BIM_W       = $clog2(BIM_ENTRIES);
    localparam int SET_W       = $clog2(COR_SETS);
    localparam int SEL_W       = $clog2(SEL_ENTRIES);
    localparam int COR_ENTRIES = COR_SETS << HIST_W;
    localparam int COR_W       = SET_W + HIST_W;

    logic [HIST_W-1:0] hist;
    logic [BIM_W-1:0]  bim_lk_idx, bim_up_idx;
    logic [COR_W-1:0]  cor_lk_idx, cor_up_idx;
    logic [SEL_W-1:0]  sel_lk_idx, sel_up_idx;
    ctr_t              bim_lk_st, bim_up_st, cor_lk_st, cor_up_st;
    logic              use_cor, bim_ok, cor_ok;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{lk_pc, upd_pc};

    always_comb begin
        bim_lk_idx = lk_pc[BIM_W+1:2];
        bim_up_idx = upd_pc[BIM_W+1:2];
        cor_lk_idx = {lk_pc[SET_W+1:2], hist};
        cor_up_idx = {upd_pc[SET_W+1:2], hist};
        sel_lk_idx = lk_pc[SEL_W+1:2];
        sel_up_idx = upd_pc[SEL_W+1:2];
        bim_ok     = (ctr_says_taken(bim_up_st) == upd_taken);
        cor_ok     = (ctr_says_taken(cor_up_st) == upd_taken);
    end

    bp_ctr_table #(.ENTRIES(BIM_ENTRIES)) u_bim (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (bim_lk_idx),
        .rd_state (bim_lk_st),
        .up_idx   (bim_up_idx),
        .up_state (bim_up_st),
        .wr_en    (upd_valid),
        .wr_taken (upd_taken)
    );

    bp_ctr_table #(.ENTRIES(COR_ENTRIES)) u_cor (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cor_lk_idx),
        .rd_state (cor_lk_st),
        .up_idx   (cor_up_idx),
        .up_state (cor_up_st),
        .wr_en    (upd_valid),
        .wr_taken (upd_taken)
    );

    bp_selector #(.ENTRIES(SEL_ENTRIES)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (sel_lk_idx),
        .rd_use_cor (use_cor),
        .up_idx     (sel_up_idx),
        .wr_en      (upd_valid),
        .cor_ok     (cor_ok),
        .bim_ok     (bim_ok)
    );

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .taken    (upd_taken),
        .hist     (hist)
    );

    always_comb begin
        pred_from_cor = use_cor;
        pred_taken    = use_cor ? ctr_says_taken(cor_lk_st) : ctr_says_taken(bim_lk_st);
    end

    // R5: prediction agrees with the selected component's counter
    assert_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_from_cor |-> (pred_taken == cor_lk_st[1]));

    assert_pick_bim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_from_cor |-> (pred_taken == bim_lk_st[1]));

endmodule

// File: tb/tournament_predictor_bench.sv
module tournament_predictor_bench;

    localparam int PC_W    = 32;
    localparam int BIM_N   = 256;
    localparam int SETS    = 64;
    localparam int SEL_N   = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            pred_taken, pred_from_cor;

    always #5 clk = ~clk;

    tournament_predictor u_tournament_predictor (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_pc         (lk_pc),
        .upd_valid     (upd_valid),
        .upd_pc        (upd_pc),
        .upd_taken     (upd_taken),
        .pred_taken    (pred_taken),
        .pred_from_cor (pred_from_cor)
    );

    typedef struct {
        logic  exp_pred;
        logic  exp_cor;
        string tag;
    } item_t;

    item_t scb[$];
    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;

    // reference model state
    int bim [BIM_N];
    int cor [SETS*4];
    int sel [SEL_N];
    int hist;
    int unsigned seed = 32'h1234_5678;

    function automatic int unsigned next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic int bi(logic [PC_W-1:0] pc); return int'((pc >> 2) % BIM_N); endfunction
    function automatic int ci(logic [PC_W-1:0] pc); return int'((pc >> 2) % SETS) * 4 + hist; endfunction
    function automatic int si(logic [PC_W-1:0] pc); return int'((pc >> 2) % SEL_N); endfunction

    task automatic model_reset();
        foreach (bim[i]) bim[i] = 1;
        foreach (cor[i]) cor[i] = 1;
        foreach (sel[i]) sel[i] = 1;
        hist = 0;
    endtask

    task automatic check(logic act_p, logic act_c, item_t e);
        total++;
        if (act_p !== e.exp_pred || act_c !== e.exp_cor) begin
            bad++;
            $display("FAIL %s: actual pred=%0b cor=%0b expected pred=%0b cor=%0b",
                     e.tag, act_p, act_c, e.exp_pred, e.exp_cor);
        end
    endtask

    // monitor: compares at the falling edge, away from the update edge
    always @(negedge clk) begin
        while (scb.size() > 0) begin
            item_t e;
            e = scb.pop_front();
            check(pred_taken, pred_from_cor, e);
        end
    end

    // driver tasks: entered just after a rising edge
    task automatic lookup(logic [PC_W-1:0] pc, string tag);
        item_t e;
        logic  uc;
        lk_pc     = pc;
        upd_valid = 1'b0;
        uc        = sel[si(pc)] >= 2;
        e.exp_cor  = uc;
        e.exp_pred = uc ? (cor[ci(pc)] >= 2) : (bim[bi(pc)] >= 2);
        e.tag      = tag;
        scb.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic update(logic [PC_W-1:0] pc, logic t);
        int  b, c, s;
        logic bok, cok;
        upd_pc    = pc;
        upd_taken = t;
        upd_valid = 1'b1;
        b = bi(pc); c = ci(pc); s = si(pc);
        bok = ((bim[b] >= 2) == t);
        cok = ((cor[c] >= 2) == t);
        if (cok && !bok && sel[s] < 3) sel[s]++;
        if (bok && !cok && sel[s] > 0) sel[s]--;
        if (t) begin
            if (bim[b] < 3) bim[b]++;
            if (cor[c] < 3) cor[c]++;
        end else begin
            if (bim[b] > 0) bim[b]--;
            if (cor[c] > 0) cor[c]--;
        end
        hist = ((hist << 1) | int'(t)) & 3;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic idle_junk(logic [PC_W-1:0] pc);
        upd_valid = 1'b0;
        upd_pc    = pc;
        upd_taken = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [PC_W-1:0] pa, pb, pc_alias;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state predicts not taken from the simple table
        for (int k = 0; k < 6; k++) lookup(32'h100 + k * 36, "R1 reset");

        // R2: saturating counter, two misses before a flip
        pa = 32'h0000_0040;
        update(pa, 1'b1); lookup(pa, "R2 one taken");
        update(pa, 1'b1); lookup(pa, "R2 two taken");
        update(pa, 1'b1); lookup(pa, "R2 saturate high");
        update(pa, 1'b0); lookup(pa, "R2 one miss");
        update(pa, 1'b0); lookup(pa, "R2 second miss");
        for (int k = 0; k < 4; k++) update(pa, 1'b0);
        lookup(pa, "R2 saturate low");

        // R3: alias in the simple table
        pc_alias = pa + BIM_N * 4;
        update(pc_alias, 1'b1); update(pc_alias, 1'b1); update(pc_alias, 1'b1);
        lookup(pa, "R3 alias shares counter");
        lookup(pc_alias, "R3 alias own view");

        // R4 R5 R6 R7: alternating branch moves the chooser to the correlator
        pb = 32'h0000_0200;
        for (int k = 0; k < 24; k++) begin
            update(pb, k[0]);
            lookup(pb, "R4 R6 alternating");
        end
        lookup(pb, "R5 chooser picks correlator");
        for (int k = 0; k < 12; k++) begin
            update(pb, 1'b1);
            lookup(pb, "R7 R6 steady run");
        end

        // R8: history shaping through two outcomes on another branch
        update(32'h300, 1'b0); update(32'h300, 1'b1);
        lookup(pb, "R8 history 01");
        update(32'h300, 1'b1);
        lookup(pb, "R8 history 11");

        // R9: junk on the update port while invalid is ignored
        for (int k = 0; k < 5; k++) idle_junk(pb + k * 4);
        lookup(pb, "R9 idle keeps state");
        lookup(pb + 4, "R9 idle neighbour");

        // mixed traffic over a small aliasing address set
        for (int k = 0; k < 600; k++) begin
            logic [PC_W-1:0] p;
            int unsigned r;
            r = next_rand();
            p = 32'h400 + ((r % 12) * 4) + (((r >> 8) % 2) * BIM_N * 4);
            update(p, ((r >> 12) % 4) != 0 ? ~hist[0] : 1'b1);
            lookup(p, "R4 R5 R6 R7 mixed");
        end

        @(negedge clk);
        @(posedge clk); #1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule